// File: doc/BRIEF.md
# Bus Error Status Interrupt Aggregator

This block sits beside the protocol engine of a conventional/PCI-X style bus port. It takes single-cycle error event pulses from that engine and records them as sticky bits in three status registers: a bus status register, an interrupt status register and a configuration status register. From the same pulses it produces the bus error pins. The system-error pin (`serr_n`) and the parity-error pin (`perr_n`) are active low and pulse for one clock per qualifying event. The block also drives a strobe that tells the error logger to capture an entry, and a strobe that tells the engine to master-abort the transaction rather than claim it.

What each event does depends on three things: the bus mode, the transaction type, and the enable bits from the command register. It is not a one-to-one map from event to flag. The system-error reporting bits are written only when the system-error pin is actually allowed to fire. The interrupt status bits pass through a mask, are ORed together and are registered into one interrupt line. Software sees the registers through a registered read port and clears them through a write-one-to-clear port.

Top module: `bus_err_aggregator`

## Requirements
- R1: An uncorrectable address/attribute event (`evt_kind`=1) sets bus status bit 15, interrupt status bit 9 and configuration status bit 20. In conventional mode (`bus_mode`=0) it also pulses `txn_ignore` high for one clock. In any PCI-X mode (`bus_mode`!=0) `txn_ignore` stays low.
- R2: `serr_n` is low for exactly one clock, one clock after a qualifying event, and only when `serr_en`=1. That same edge sets bus status bit 14 and interrupt status bits 10 and 4. With `serr_en`=0 the pin stays high and none of these three bits is set.
- R3: A correctable address/attribute event (`evt_kind`=2) in PCI-X mode 2 (`bus_mode`=2) sets interrupt status bit 14 and pulses `log_upd`. It never affects the pins. In any other mode it changes nothing.
- R4: `log_upd` pulses for one clock after an uncorrectable address/attribute event only when `bus_mode`=2.
- R5: An outbound read data error (`evt_kind`=3) sets bus status bits 8 and 15 and interrupt status bits 0 and 9. It pulses `perr_n` low in every mode when `perr_en`=1. It qualifies for a system error only when `bus_mode`!=0.
- R6: An outbound write data error (`evt_kind`=4) sets bus status bit 8 and interrupt status bit 0. It never pulses `perr_n`. It qualifies for a system error only when `bus_mode`!=0 or `evt_msi`=1.
- R7: Every status bit is sticky until a write with `wr_en`=1 carries a one in that bit position. `wr_sel` picks the register: 0 bus, 1 interrupt, 2 configuration. If a set and a clear hit the same bit on the same edge, the bit ends up set.
- R8: `irq` is registered. It is high one clock after any interrupt status bit is set whose mask is 0. The `irq_mask` bits map as follows: [0] masks bit 0, [1] masks bit 4, [2] masks bit 9, [3] masks bit 10, [4] masks bit 14.
- R9: `rd_data` shows, one clock later, the register picked by `rd_sel` (0 bus, 1 interrupt, 2 configuration). `rd_sel`=3 reads zero.
- R10: After synchronous reset all status registers read zero, `serr_n` and `perr_n` are high, and `irq`, `log_upd` and `txn_ignore` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_kind | input | 3 | Error event pulse: 0 none, 1 uncorrectable addr/attr, 2 correctable addr/attr, 3 outbound read data, 4 outbound write data |
| evt_msi | input | 1 | Outbound write is a message-signalled interrupt write |
| bus_mode | input | 2 | 0 conventional, 1 PCI-X mode 1, 2 PCI-X mode 2, 3 treated as mode 1 |
| serr_en | input | 1 | Command register system-error enable |
| perr_en | input | 1 | Command register parity-error response enable |
| irq_mask | input | 5 | Interrupt masks, 1 = masked (mapping in R8) |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_sel | input | 2 | Register targeted by the clear |
| wr_data | input | DW | Clear mask |
| rd_sel | input | 2 | Register selected for reading |
| rd_data | output | DW | Registered read data |
| serr_n | output | 1 | System-error pin, active low |
| perr_n | output | 1 | Parity-error pin, active low |
| irq | output | 1 | Registered masked interrupt |
| log_upd | output | 1 | Error log update strobe |
| txn_ignore | output | 1 | Master-abort the current transaction |

## Verification
The hardest case to reach from the ports is a new error event landing on the same edge as a write-one-to-clear of the very bit that event sets. A second hard case is the write-data path, where only the MSI qualifier decides whether conventional mode raises a system error. The bench drives an event and a matching clear in one cycle and then reads the register back. It also walks the write event through every combination of mode and MSI flag with the enable on and off. A behavioural model predicts every output on every clock, so an error in an unexpected cycle is caught as well as a missing one.

// File: rtl/berr_pkg.sv
package berr_pkg;

  typedef enum logic [2:0] {
    EV_NONE     = 3'd0,
    EV_ADDR_UNC = 3'd1,
    EV_ADDR_COR = 3'd2,
    EV_RD_DATA  = 3'd3,
    EV_WR_DATA  = 3'd4
  } evt_e;

  localparam int BS_MPE      = 8;
  localparam int BS_SERR     = 14;
  localparam int BS_DPE      = 15;
  localparam int IS_MPE      = 0;
  localparam int IS_SERR_DET = 4;
  localparam int IS_DPE      = 9;
  localparam int IS_SERR     = 10;
  localparam int IS_COR      = 14;
  localparam int CS_UNC      = 20;

  localparam int NREG   = 3;
  localparam int SEL_W  = 2;
  localparam int MSK_W  = 5;

  typedef struct packed {
    logic serr;
    logic perr;
    logic log;
    logic ign;
  } act_t;

endpackage

// File: rtl/berr_decode.sv
module berr_decode
  import berr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [2:0]    kind,
  input  logic [1:0]    mode,
  input  logic          msi,
  input  logic          serr_en,
  input  logic          perr_en,
  output logic [DW-1:0] set_bus,
  output logic [DW-1:0] set_irq,
  output logic [DW-1:0] set_cfg,
  output act_t          act
);

  logic pcix, m2, conv;
  logic serr_req, dpe, mpe;

  assign pcix = (mode != 2'd0);
  assign m2   = (mode == 2'd2);
  assign conv = ~pcix;

  always_comb begin
    set_bus  = '0;
    set_irq  = '0;
    set_cfg  = '0;
    act      = '0;
    serr_req = 1'b0;
    dpe      = 1'b0;
    mpe      = 1'b0;
    case (evt_e'(kind))
      EV_ADDR_UNC: begin
        serr_req        = 1'b1;
        dpe             = 1'b1;
        set_cfg[CS_UNC] = 1'b1;
        act.log         = m2;
        act.ign         = conv;
      end
      EV_ADDR_COR: begin
        if (m2) begin
          set_irq[IS_COR] = 1'b1;
          act.log         = 1'b1;
        end
      end
      EV_RD_DATA: begin
        mpe      = 1'b1;
        dpe      = 1'b1;
        act.perr = perr_en;
        serr_req = pcix;
      end
      EV_WR_DATA: begin
        mpe      = 1'b1;
        serr_req = pcix | msi;
      end
      default: ;
    endcase
    act.serr = serr_req & serr_en;
    if (dpe) begin
      set_bus[BS_DPE] = 1'b1;
      set_irq[IS_DPE] = 1'b1;
    end
    if (mpe) begin
      set_bus[BS_MPE] = 1'b1;
      set_irq[IS_MPE] = 1'b1;
    end
    if (act.serr) begin
      set_bus[BS_SERR]     = 1'b1;
      set_irq[IS_SERR]     = 1'b1;
      set_irq[IS_SERR_DET] = 1'b1;
    end
  end

endmodule

// File: rtl/berr_w1c.sv
module berr_w1c #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_mask,
  output logic [DW-1:0] q
);

  logic [DW-1:0] clr_v;
  assign clr_v = clr_en ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_v) | set;
  end

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (($past(q) & ~$past(clr_v) & ~q) == '0)); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (($past(set) & ~q) == '0)); // R7

endmodule

// File: rtl/berr_irq.sv
module berr_irq #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sts,
  input  logic [DW-1:0] mask,
  output logic          irq_o
);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(sts & ~mask);
  end

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(sts) != '0)); // R8

endmodule

// File: rtl/bus_err_aggregator.sv
module bus_err_aggregator
  import berr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       evt_kind,
  input  logic             evt_msi,
  input  logic [1:0]       bus_mode,
  input  logic             serr_en,
  input  logic             perr_en,
  input  logic [MSK_W-1:0] irq_mask,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [DW-1:0]    rd_data,
  output logic             serr_n,
  output logic             perr_n,
  output logic             irq,
  output logic             log_upd,
  output logic             txn_ignore
);

  logic [DW-1:0] set_arr [NREG];
  logic [DW-1:0] sts_arr [NREG];
  logic [DW-1:0] eff_mask;
  act_t          act;

  berr_decode #(.DW(DW)) u_dec (
    .kind    (evt_kind),
    .mode    (bus_mode),
    .msi     (evt_msi),
    .serr_en (serr_en),
    .perr_en (perr_en),
    .set_bus (set_arr[0]),
    .set_irq (set_arr[1]),
    .set_cfg (set_arr[2]),
    .act     (act)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    berr_w1c #(.DW(DW)) u_reg (
      .clk      (clk),
      .rst      (rst),
      .set      (set_arr[g]),
      .clr_en   (wr_en && (wr_sel == SEL_W'(g))),
      .clr_mask (wr_data),
      .q        (sts_arr[g])
    );
  end

  always_comb begin
    eff_mask              = '0;
    eff_mask[IS_MPE]      = irq_mask[0];
    eff_mask[IS_SERR_DET] = irq_mask[1];
    eff_mask[IS_DPE]      = irq_mask[2];
    eff_mask[IS_SERR]     = irq_mask[3];
    eff_mask[IS_COR]      = irq_mask[4];
  end

  berr_irq #(.DW(DW)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .sts   (sts_arr[1]),
    .mask  (eff_mask),
    .irq_o (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      serr_n     <= 1'b1;
      perr_n     <= 1'b1;
      log_upd    <= 1'b0;
      txn_ignore <= 1'b0;
      rd_data    <= '0;
    end else begin
      serr_n     <= ~act.serr;
      perr_n     <= ~act.perr;
      log_upd    <= act.log;
      txn_ignore <= act.ign;
      case (rd_sel)
        2'd0:    rd_data <= sts_arr[0];
        2'd1:    rd_data <= sts_arr[1];
        2'd2:    rd_data <= sts_arr[2];
        default: rd_data <= '0;
      endcase
    end
  end

  AST_SERR_GATED: assert property (@(posedge clk) disable iff (rst)
    !serr_n |-> (sts_arr[0][BS_SERR] && $past(serr_en))); // R2

  AST_PERR_RECORDED: assert property (@(posedge clk) disable iff (rst)
    !perr_n |-> (sts_arr[0][BS_MPE] && $past(perr_en))); // R5

  AST_LOG_MODE2: assert property (@(posedge clk) disable iff (rst)
    log_upd |-> ($past(bus_mode) == 2'd2)); // R4

  AST_IGN_CONV: assert property (@(posedge clk) disable iff (rst)
    txn_ignore |-> ($past(bus_mode) == 2'd0)); // R1

endmodule

// File: tb/sim_bus_err_aggregator.sv
module sim_bus_err_aggregator;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  evt_kind = '0;
  logic        evt_msi = 1'b0;
  logic [1:0]  bus_mode = '0;
  logic        serr_en = 1'b0;
  logic        perr_en = 1'b0;
  logic [4:0]  irq_mask = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        serr_n, perr_n, irq, log_upd, txn_ignore;

  int checks = 0;
  int failures = 0;
  string cur_req = "R10";

  logic [31:0] m_bus = '0, m_irq = '0, m_cfg = '0;
  logic [31:0] e_rd = '0;
  logic e_serr_n = 1'b1, e_perr_n = 1'b1, e_irq = 1'b0, e_log = 1'b0, e_ign = 1'b0;

  always #5 clk = ~clk;

  bus_err_aggregator u0 (
    .clk(clk), .rst(rst), .evt_kind(evt_kind), .evt_msi(evt_msi),
    .bus_mode(bus_mode), .serr_en(serr_en), .perr_en(perr_en),
    .irq_mask(irq_mask), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .serr_n(serr_n), .perr_n(perr_n),
    .irq(irq), .log_upd(log_upd), .txn_ignore(txn_ignore)
  );

  task automatic chk(input string name, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%h exp=%h at %0t", cur_req, name, got, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [31:0] msk;
    logic fs, fp;
    if (rst) begin
      m_bus = 0; m_irq = 0; m_cfg = 0; e_rd = 0;
      e_serr_n = 1; e_perr_n = 1; e_irq = 0; e_log = 0; e_ign = 0;
    end else begin
      case (rd_sel)
        0: e_rd = m_bus;
        1: e_rd = m_irq;
        2: e_rd = m_cfg;
        default: e_rd = 0;
      endcase
      msk = 0;
      msk[0] = irq_mask[0]; msk[4] = irq_mask[1]; msk[9] = irq_mask[2];
      msk[10] = irq_mask[3]; msk[14] = irq_mask[4];
      e_irq = ((m_irq & ~msk) != 0);
      if (wr_en) begin
        if (wr_sel == 0) m_bus = m_bus & ~wr_data;
        if (wr_sel == 1) m_irq = m_irq & ~wr_data;
        if (wr_sel == 2) m_cfg = m_cfg & ~wr_data;
      end
      fs = 0; fp = 0; e_log = 0; e_ign = 0;
      if (evt_kind == 1) begin
        m_bus[15] = 1; m_irq[9] = 1; m_cfg[20] = 1;
        fs = serr_en; e_log = (bus_mode == 2); e_ign = (bus_mode == 0);
      end else if (evt_kind == 2) begin
        if (bus_mode == 2) begin m_irq[14] = 1; e_log = 1; end
      end else if (evt_kind == 3) begin
        m_bus[8] = 1; m_bus[15] = 1; m_irq[0] = 1; m_irq[9] = 1;
        fp = perr_en; fs = serr_en && (bus_mode != 0);
      end else if (evt_kind == 4) begin
        m_bus[8] = 1; m_irq[0] = 1;
        fs = serr_en && ((bus_mode != 0) || evt_msi);
      end
      if (fs) begin m_bus[14] = 1; m_irq[10] = 1; m_irq[4] = 1; end
      e_serr_n = ~fs; e_perr_n = ~fp;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("serr_n", 32'(serr_n), 32'(e_serr_n));
    chk("perr_n", 32'(perr_n), 32'(e_perr_n));
    chk("irq", 32'(irq), 32'(e_irq));
    chk("log_upd", 32'(log_upd), 32'(e_log));
    chk("txn_ignore", 32'(txn_ignore), 32'(e_ign));
    chk("rd_data", rd_data, e_rd);
    evt_kind = 0; evt_msi = 0; wr_en = 0; wr_data = 0;
  endtask

  task automatic ev(input logic [2:0] k, input logic [1:0] md, input logic msi);
    evt_kind = k; bus_mode = md; evt_msi = msi;
    cyc();
    cyc();
  endtask

  task automatic clr_all();
    for (int s = 0; s < 3; s++) begin
      wr_en = 1; wr_sel = 2'(s); wr_data = '1;
      cyc();
    end
    cyc();
  endtask

  task automatic read_all();
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s);
      cyc();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc();
    rst = 0;
    // R10: reset state visible on every output and every register
    cur_req = "R10";
    chk("serr_n_reset", 32'(serr_n), 32'd1);
    chk("irq_reset", 32'(irq), 32'd0);
    read_all();

    // R1 and R2: uncorrectable address error, conventional and PCI-X, enable on/off
    cur_req = "R1";
    serr_en = 1; perr_en = 1;
    ev(3'd1, 2'd0, 1'b0);
    read_all();
    clr_all();
    cur_req = "R2";
    serr_en = 0;
    ev(3'd1, 2'd1, 1'b0);
    read_all();
    clr_all();
    serr_en = 1;
    ev(3'd1, 2'd1, 1'b0);
    read_all();
    clr_all();

    // R4: log update only in mode 2
    cur_req = "R4";
    ev(3'd1, 2'd2, 1'b0);
    ev(3'd1, 2'd3, 1'b0);
    clr_all();

    // R3: correctable error only in mode 2
    cur_req = "R3";
    for (int md = 0; md < 4; md++) begin
      ev(3'd2, 2'(md), 1'b0);
      read_all();
    end
    clr_all();

    // R5: outbound read data error across modes and enables
    cur_req = "R5";
    for (int md = 0; md < 3; md++)
      for (int en = 0; en < 4; en++) begin
        serr_en = en[0]; perr_en = en[1];
        ev(3'd3, 2'(md), 1'b0);
        rd_sel = 0; cyc();
        clr_all();
      end

    // R6: outbound write data error, MSI qualifier
    cur_req = "R6";
    for (int md = 0; md < 3; md++)
      for (int q = 0; q < 4; q++) begin
        serr_en = q[0]; perr_en = 1;
        ev(3'd4, 2'(md), q[1]);
        rd_sel = 0; cyc();
        rd_sel = 1; cyc();
        clr_all();
      end

    // R7: sticky, partial clear, same-edge set and clear
    cur_req = "R7";
    serr_en = 1; perr_en = 1;
    ev(3'd3, 2'd1, 1'b0);
    wr_en = 1; wr_sel = 0; wr_data = 32'h0000_0100;
    cyc();
    read_all();
    wr_en = 1; wr_sel = 1; wr_data = 32'hFFFF_FFFF;
    evt_kind = 3'd3; bus_mode = 2'd1;
    cyc();
    read_all();
    wr_en = 1; wr_sel = 2; wr_data = 32'hFFFF_FFFF;
    evt_kind = 3'd1; bus_mode = 2'd0;
    cyc();
    read_all();
    clr_all();

    // R8: mask mapping, one interrupt bit at a time
    cur_req = "R8";
    for (int b = 0; b < 5; b++) begin
      irq_mask = 5'(1 << b);
      ev(3'd1, 2'd2, 1'b0);
      ev(3'd2, 2'd2, 1'b0);
      ev(3'd4, 2'd0, 1'b0);
      irq_mask = 5'h1F;
      cyc(); cyc();
      irq_mask = ~5'(1 << b);
      cyc(); cyc();
      clr_all();
      irq_mask = 0;
    end

    // R9: read selector including the unused code
    cur_req = "R9";
    ev(3'd1, 2'd2, 1'b0);
    ev(3'd3, 2'd2, 1'b0);
    read_all();
    rd_sel = 3; cyc();
    chk("rd_sel3", rd_data, 32'd0);
    rd_sel = 2; cyc();
    chk("rd_cfg", rd_data, 32'h0010_0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule